// File: doc/BRIEF.md
# USB Host Interrupt Register Bank

This block keeps the interrupt bookkeeping of a USB host controller that follows the open host controller register model, and it drives one interrupt request line. Single-cycle event pulses arrive from the surrounding frame timer, list processor, root hub and writeback logic. Each pulse latches a sticky status bit. Software clears a status bit by writing a 1 to it.

A set of per-source enables, plus one master enable, decides whether a pending status bit raises the request line. One enable register sits behind two addresses. A write to the set alias turns on every enable bit that is written as 1. A write to the clear alias turns off every enable bit that is written as 1. The block also watches the most significant bit of the 16-bit frame number and records a frame wrap event each time that bit toggles. One source, the unrecoverable error, is not implemented and always reads zero.

Top module: `usbh_irq_bank`

## Requirements
- R1: After reset, the status register at offset 0x0C and the enable register at offsets 0x10 and 0x14 all read 0x00000000, and `irq_out` is 0.
- R2: Each event pulse sets its own status bit, and the bit stays set until software clears it. The bit positions are: scheduling overrun bit 0, writeback done bit 1, start of frame bit 2, resume bit 3, root hub change bit 6, ownership change bit 30.
- R3: Writing to offset 0x0C clears every status bit written as 1. Status bits written as 0 keep their value.
- R4: If an event pulse and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R5: Status bit 5 is set when bit 15 of `frame_num` changes, whether it rises or falls. Changes to bits 14:0 alone do not set it.
- R6: Writing to offset 0x10 sets every enable bit written as 1. Enable bits written as 0 keep their value.
- R7: Writing to offset 0x14 clears every enable bit written as 1, and this includes master enable bit 31. Enable bits written as 0 keep their value.
- R8: Offsets 0x10 and 0x14 both read the same current enable value.
- R9: Bit 4 and bits 29:7 always read 0 in both the status and the enable registers, whatever value is written to them.
- R10: `irq_out` is registered. One clock after the status or enable registers change, it equals 1 exactly when enable bit 31 is 1 and at least one source has both its status bit and its enable bit at 1.
- R11: While enable bit 31 is 0, `irq_out` stays 0 even when an enabled source is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_sched_overrun | input | 1 | Scheduling overrun pulse |
| ev_done_wb | input | 1 | Done-queue writeback pulse |
| ev_sof | input | 1 | Start of frame pulse |
| ev_resume | input | 1 | Downstream resume detected pulse |
| ev_root_hub | input | 1 | Root hub or port status changed pulse |
| ev_owner | input | 1 | Ownership change pulse |
| frame_num | input | 16 | Current frame number |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Write strobe for the register at `reg_addr` |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_out | output | 1 | Interrupt request |

## Verification
The assertions assume the following about the inputs:
- Event inputs are synchronous to `clk`.
- A write strobe targets exactly one offset per cycle.
- `frame_num` is a stable synchronous value, so a toggle of bit 15 is seen on one clock edge only.

The stimulus meets these assumptions. All inputs are driven on the falling edge. Each write is held for exactly one rising edge. Frame numbers change only between edges. The one deliberate overlap, an event pulse and a clear of the same bit in the same cycle, is applied on purpose to exercise the priority rule.

// File: rtl/usbh_irq_pkg.sv
package usbh_irq_pkg;

  localparam int DW         = 32;
  localparam int NSRC       = 7;
  localparam int MASTER_BIT = 31;
  localparam int WRAP_SRC   = 4;   // source index fed by the frame wrap detector

  localparam logic [7:0] OFF_STATUS = 8'h0C;
  localparam logic [7:0] OFF_EN_SET = 8'h10;
  localparam logic [7:0] OFF_EN_CLR = 8'h14;

  typedef logic [DW-1:0] word_t;

  // Maps a source index to its bit position in the status and enable words.
  function automatic int src_pos(input int idx);
    case (idx)
      0:       return 0;   // scheduling overrun
      1:       return 1;   // writeback done
      2:       return 2;   // start of frame
      3:       return 3;   // resume
      4:       return 5;   // frame wrap
      5:       return 6;   // root hub change
      default: return 30;  // ownership change
    endcase
  endfunction

  function automatic word_t build_src_mask();
    word_t m;
    m = '0;
    for (int i = 0; i < NSRC; i++) m[src_pos(i)] = 1'b1;
    return m;
  endfunction

  localparam word_t STATUS_MASK = build_src_mask();
  localparam word_t ENABLE_MASK = build_src_mask() | (word_t'(1) << MASTER_BIT);

  function automatic word_t apply_w1s(input word_t cur, input word_t wd);
    return cur | (wd & ENABLE_MASK);
  endfunction

  function automatic word_t apply_w1c(input word_t cur, input word_t wd);
    return cur & ~(wd & ENABLE_MASK);
  endfunction

  function automatic logic irq_due(input word_t st, input word_t en);
    return en[MASTER_BIT] & (|(st & en & STATUS_MASK));
  endfunction

endpackage

// File: rtl/usbh_frame_wrap.sv
module usbh_frame_wrap (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_msb,
  output logic wrap_evt
);
  logic prev_q;
  logic primed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= frame_msb;
      primed_q <= 1'b1;
    end
  end

  assign wrap_evt = primed_q & (prev_q ^ frame_msb);

  p_wrap_needs_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |-> (frame_msb != prev_q));

endmodule

// File: rtl/usbh_irq_status.sv
module usbh_irq_status
  import usbh_irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev_set,
  input  logic         clr_wr,
  input  word_t        clr_data,
  output word_t        status
);
  logic [N-1:0] bit_q;
  logic [N-1:0] clr_hit;

  for (genvar i = 0; i < N; i++) begin : g_src
    localparam int P = src_pos(i);
    assign clr_hit[i] = clr_wr & clr_data[P];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bit_q[i] <= 1'b0;
      else        bit_q[i] <= ev_set[i] | (bit_q[i] & ~clr_hit[i]);
    end
  end

  always_comb begin
    status = '0;
    for (int i = 0; i < N; i++) status[src_pos(i)] = bit_q[i];
  end

  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(bit_q) & ~$past(clr_hit) & ~bit_q) == '0));

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_set != '0) |=> (($past(ev_set) & ~bit_q) == '0));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit != '0) |=> (($past(clr_hit) & ~$past(ev_set) & bit_q) == '0));

endmodule

// File: rtl/usbh_irq_enable.sv
module usbh_irq_enable
  import usbh_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  set_wr,
  input  logic  clr_wr,
  input  word_t wdata,
  output word_t enable
);
  word_t en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (set_wr) en_q <= apply_w1s(en_q, wdata);
    else if (clr_wr) en_q <= apply_w1c(en_q, wdata);
  end

  assign enable = en_q;

  p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> ((($past(wdata) & ENABLE_MASK) & ~en_q) == '0));

  p_master_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !set_wr && wdata[MASTER_BIT]) |=> !en_q[MASTER_BIT]);

  p_enable_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q & ~ENABLE_MASK) == '0);

endmodule

// File: rtl/usbh_irq_req.sv
module usbh_irq_req
  import usbh_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t status,
  input  word_t enable,
  output logic  irq
);
  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_due(status, enable);
  end

  assign irq = irq_q;

  p_master_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable[MASTER_BIT] |=> !irq_q);

  p_needs_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & enable) == '0) |=> !irq_q);

endmodule

// File: rtl/usbh_irq_bank.sv
module usbh_irq_bank
  import usbh_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_sched_overrun,
  input  logic              ev_done_wb,
  input  logic              ev_sof,
  input  logic              ev_resume,
  input  logic              ev_root_hub,
  input  logic              ev_owner,
  input  logic [15:0]       frame_num,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_out
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_EN_SET = ADDR_W'(OFF_EN_SET);
  localparam logic [ADDR_W-1:0] A_EN_CLR = ADDR_W'(OFF_EN_CLR);

  logic            wrap_evt;
  logic [NSRC-1:0] ev_vec;
  logic            wr_status;
  logic            wr_en_set;
  logic            wr_en_clr;
  word_t           status_w;
  word_t           enable_w;

  assign wr_status = reg_wr && (reg_addr == A_STATUS);
  assign wr_en_set = reg_wr && (reg_addr == A_EN_SET);
  assign wr_en_clr = reg_wr && (reg_addr == A_EN_CLR);

  assign ev_vec = {ev_owner, ev_root_hub, wrap_evt, ev_resume,
                   ev_sof, ev_done_wb, ev_sched_overrun};

  usbh_frame_wrap u_wrap (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_msb (frame_num[15]),
    .wrap_evt  (wrap_evt)
  );

  usbh_irq_status #(.N(NSRC)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_set   (ev_vec),
    .clr_wr   (wr_status),
    .clr_data (reg_wdata),
    .status   (status_w)
  );

  usbh_irq_enable u_enable (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_wr (wr_en_set),
    .clr_wr (wr_en_clr),
    .wdata  (reg_wdata),
    .enable (enable_w)
  );

  usbh_irq_req u_req (
    .clk    (clk),
    .rst_n  (rst_n),
    .status (status_w),
    .enable (enable_w),
    .irq    (irq_out)
  );

  always_comb begin
    if (reg_addr == A_STATUS)
      reg_rdata = status_w;
    else if (reg_addr == A_EN_SET || reg_addr == A_EN_CLR)
      reg_rdata = enable_w;
    else
      reg_rdata = '0;
  end

  p_alias_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_EN_CLR) |-> (reg_rdata == enable_w));

  p_reserved_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~ENABLE_MASK) == '0);

  p_wrap_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> status_w[5]);

endmodule

// File: tb/usbh_irq_bank_test.sv
`timescale 1ns/1ps
module usbh_irq_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_sched_overrun = 1'b0, ev_done_wb = 1'b0, ev_sof = 1'b0;
  logic        ev_resume = 1'b0, ev_root_hub = 1'b0, ev_owner = 1'b0;
  logic [15:0] frame_num = 16'h0000;
  logic [7:0]  reg_addr = 8'h00;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  usbh_irq_bank uut (
    .clk(clk), .rst_n(rst_n),
    .ev_sched_overrun(ev_sched_overrun), .ev_done_wb(ev_done_wb),
    .ev_sof(ev_sof), .ev_resume(ev_resume), .ev_root_hub(ev_root_hub),
    .ev_owner(ev_owner), .frame_num(frame_num),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 32'h0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    case (idx)
      0: ev_sched_overrun = 1'b1;
      1: ev_done_wb = 1'b1;
      2: ev_sof = 1'b1;
      3: ev_resume = 1'b1;
      4: ev_root_hub = 1'b1;
      default: ev_owner = 1'b1;
    endcase
    @(negedge clk);
    {ev_sched_overrun, ev_done_wb, ev_sof, ev_resume, ev_root_hub, ev_owner} = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h0C, d); chk("R1 status", d, 32'h0);
    rd(8'h10, d); chk("R1 enable set alias", d, 32'h0);
    rd(8'h14, d); chk("R1 enable clr alias", d, 32'h0);
    chk("R1 irq", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_events;
    logic [31:0] d;
    for (int i = 0; i < 6; i++) pulse(i);
    repeat (3) @(negedge clk);
    rd(8'h0C, d); chk("R2 sticky status", d, 32'h4000004F);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    wr(8'h0C, 32'h00000005);
    rd(8'h0C, d); chk("R3 clear bits 0,2", d, 32'h4000004A);
    wr(8'h0C, 32'h00000000);
    rd(8'h0C, d); chk("R3 zero write no effect", d, 32'h4000004A);
  endtask

  task automatic t_set_wins;
    logic [31:0] d;
    @(negedge clk);
    reg_addr = 8'h0C; reg_wdata = 32'h00000002; reg_wr = 1'b1; ev_done_wb = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; ev_done_wb = 1'b0; reg_wdata = 32'h0;
    rd(8'h0C, d); chk("R4 set beats clear", d, 32'h4000004A);
    wr(8'h0C, 32'hFFFFFFFF);
    rd(8'h0C, d); chk("R3 clear all", d, 32'h0);
  endtask

  task automatic t_frame;
    logic [31:0] d;
    @(negedge clk); frame_num = 16'h7FFF;
    repeat (2) @(negedge clk);
    rd(8'h0C, d); chk("R5 low bits no wrap", d, 32'h0);
    frame_num = 16'h8000;
    repeat (2) @(negedge clk);
    rd(8'h0C, d); chk("R5 rising msb", d, 32'h00000020);
    wr(8'h0C, 32'h00000020);
    rd(8'h0C, d); chk("R5 cleared", d, 32'h0);
    frame_num = 16'h0000;
    repeat (2) @(negedge clk);
    rd(8'h0C, d); chk("R5 falling msb", d, 32'h00000020);
    wr(8'h0C, 32'h00000020);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    wr(8'h10, 32'h00000044);
    rd(8'h10, d); chk("R6 set", d, 32'h00000044);
    rd(8'h14, d); chk("R8 alias read", d, 32'h00000044);
    wr(8'h10, 32'h00000000);
    rd(8'h10, d); chk("R6 zero write no effect", d, 32'h00000044);
    wr(8'h10, 32'h80000001);
    rd(8'h14, d); chk("R6 set master", d, 32'h80000045);
    wr(8'h14, 32'h00000040);
    rd(8'h10, d); chk("R7 clear bit 6", d, 32'h80000005);
    wr(8'h14, 32'h00000000);
    rd(8'h10, d); chk("R7 zero write no effect", d, 32'h80000005);
  endtask

  task automatic t_reserved;
    logic [31:0] d;
    wr(8'h10, 32'h3FFFFF90);
    rd(8'h10, d); chk("R9 enable reserved ignored", d, 32'h80000005);
    rd(8'h0C, d); chk("R9 status reserved zero", d, 32'h0);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    chk("R10 idle irq", {31'b0, irq_out}, 32'h0);
    pulse(2);
    chk("R10 one clock latency", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    chk("R10 irq asserted", {31'b0, irq_out}, 32'h1);
    wr(8'h14, 32'h80000000);
    @(negedge clk);
    chk("R11 master off", {31'b0, irq_out}, 32'h0);
    rd(8'h0C, d); chk("R11 status still pending", d, 32'h00000004);
    wr(8'h10, 32'h80000000);
    @(negedge clk);
    chk("R10 master back on", {31'b0, irq_out}, 32'h1);
    wr(8'h0C, 32'h00000004);
    @(negedge clk);
    chk("R10 cleared source", {31'b0, irq_out}, 32'h0);
    pulse(3);
    repeat (2) @(negedge clk);
    chk("R10 disabled source", {31'b0, irq_out}, 32'h0);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_events;
    t_w1c;
    t_set_wins;
    t_frame;
    t_enable;
    t_reserved;
    t_irq;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule